// File: doc/BRIEF.md
# Frame-Synchronized Display Control Register

This block is the general control word of a display controller. Software writes a 32-bit value over a simple register bus. The upper seven bits govern debug routing, RAM diagnostics and signature capture, and they act on the cycle after the write. The lower bits only reach the active copy when the video timing logic signals the start of a new frame or interlaced field. This keeps a control change from tearing a picture that is halfway through scan-out.

A readback of the register returns exactly what software last wrote, even if part of that value is still waiting for a frame boundary. Switching the diagnostic-mode bit from 0 to 1 produces a single-cycle pulse. That pulse clears the read and write pointers of the display FIFO and the line buffer. The block also decodes the buffer read/write select into separate read-address and write-address enables, and both of these stay off outside diagnostic mode.

Top module: `fsync_ctl_reg`

## Requirements
- R1: After reset, the active word, the readback word, every decoded output and the pointer-clear pulse are all zero.
- R2: Bits 24..0 of the active word change only on a cycle where `frameStart` is high. On that cycle they take the deferred bits of the last write made before that cycle.
- R3: Bits 31..25 of the active word equal the written bits on the cycle after any write, whether or not `frameStart` is high.
- R4: The decoded outputs follow fixed bit positions in the active word: bit 31 debug enable, bit 30 debug source (0 = FIFO control, 1 = memory control), bit 29 buffer read/write select, bit 28 diagnostic mode, bit 27 CRC mode, bit 26 signature free-run, bit 25 signature readout enable.
- R5: While diagnostic mode is active, select bit 29 = 0 raises only `diagWrAddrEn` and select bit 29 = 1 raises only `diagRdAddrEn`. Outside diagnostic mode both enables are low.
- R6: `ptrClear` is high for exactly one cycle, in the cycle after active bit 28 goes from 0 to 1. It stays low when the bit stays at 1 or falls to 0.
- R7: `busRdData` returns the full last-written word, including deferred bits not yet applied.
- R8: If a write lands in the same cycle as `frameStart`, that frame start applies the previous pending deferred bits. The new deferred bits wait for the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Last written word |
| frameStart | input | 1 | One-cycle frame/field start pulse |
| activeCfg | output | 32 | Active control word |
| dbgEnable | output | 1 | Debug port enable |
| dbgSelMem | output | 1 | Debug source: 0 FIFO control, 1 memory control |
| diagMode | output | 1 | RAM diagnostic mode |
| diagRdAddrEn | output | 1 | Diagnostic read address enable |
| diagWrAddrEn | output | 1 | Diagnostic write address enable |
| crcModeSel | output | 1 | Signature CRC algorithm select |
| sigFreeRun | output | 1 | Continuous signature capture |
| sigRdEn | output | 1 | Signature readout enable |
| ptrClear | output | 1 | FIFO and line-buffer pointer clear pulse |

## Verification
The bench writes deferred bits and then idles across several cycles without a frame start. A design that latched those bits early would show the new lower bits in the active word too soon.

It also issues a write in the same cycle as a frame start. A design that forwarded the fresh write data would apply the new deferred bits one frame early.

Diagnostic mode is entered, held while the select bit is flipped, left, and entered again. This catches a pulse that repeats while the bit stays high, fires on the falling edge, or lasts more than one cycle. It also catches address enables that leak out while diagnostic mode is off.

// File: rtl/fsync_ctl_pkg.sv
`timescale 1ns/1ps
package fsync_ctl_pkg;
  localparam int CFG_W       = 32;
  localparam int BIT_DBG_EN  = 31;
  localparam int BIT_DBG_SEL = 30;
  localparam int BIT_BUF_RW  = 29;
  localparam int BIT_DIAG    = 28;
  localparam int BIT_CRC     = 27;
  localparam int BIT_SIG_RUN = 26;
  localparam int BIT_SIG_RD  = 25;

  typedef struct packed {
    logic loadShadow;     // capture bus word for readback / pending
    logic loadImmediate;  // apply immediate field group now
    logic latchDeferred;  // frame boundary: move pending into active
  } cfgStrobe_t;
endpackage

// File: rtl/fsync_ctl_ctrl.sv
`timescale 1ns/1ps
module fsync_ctl_ctrl
  import fsync_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWrEn,
  input  logic       frameStart,
  input  logic       diagActive,
  output cfgStrobe_t strobe,
  output logic       ptrClear
);
  logic diagPrev;

  always_comb begin
    strobe.loadShadow    = busWrEn;
    strobe.loadImmediate = busWrEn;
    strobe.latchDeferred = frameStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) diagPrev <= 1'b0;
    else       diagPrev <= diagActive;
  end

  assign ptrClear = diagActive & ~diagPrev;

  assert_ptr_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    ptrClear |=> !ptrClear);
  assert_ptr_needs_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    (diagActive && $stable(diagActive)) |-> !ptrClear);
endmodule

// File: rtl/fsync_ctl_data.sv
`timescale 1ns/1ps
module fsync_ctl_data
  import fsync_ctl_pkg::*;
#(
  parameter int               W        = CFG_W,
  parameter logic [W-1:0]     IMM_MASK = 32'hFE00_0000
) (
  input  logic         clk,
  input  logic         rstN,
  input  cfgStrobe_t   strobe,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] shadowWord,
  output logic [W-1:0] activeWord,
  output logic         dbgEnable,
  output logic         dbgSelMem,
  output logic         diagMode,
  output logic         diagRdAddrEn,
  output logic         diagWrAddrEn,
  output logic         crcModeSel,
  output logic         sigFreeRun,
  output logic         sigRdEn
);
  localparam logic [W-1:0] DEF_MASK = ~IMM_MASK;

  logic [W-1:0] shadowQ, activeQ, nextActive;

  always_comb begin
    nextActive = activeQ;
    if (strobe.latchDeferred)
      nextActive = (nextActive & IMM_MASK) | (shadowQ & DEF_MASK);
    if (strobe.loadImmediate)
      nextActive = (nextActive & DEF_MASK) | (wrData & IMM_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ <= '0;
      activeQ <= '0;
    end else begin
      if (strobe.loadShadow) shadowQ <= wrData;
      activeQ <= nextActive;
    end
  end

  assign shadowWord   = shadowQ;
  assign activeWord   = activeQ;
  assign dbgEnable    = activeQ[BIT_DBG_EN];
  assign dbgSelMem    = activeQ[BIT_DBG_SEL];
  assign diagMode     = activeQ[BIT_DIAG];
  assign diagRdAddrEn = activeQ[BIT_DIAG] &  activeQ[BIT_BUF_RW];
  assign diagWrAddrEn = activeQ[BIT_DIAG] & ~activeQ[BIT_BUF_RW];
  assign crcModeSel   = activeQ[BIT_CRC];
  assign sigFreeRun   = activeQ[BIT_SIG_RUN];
  assign sigRdEn      = activeQ[BIT_SIG_RD];

  assert_deferred_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchDeferred |=> ((activeQ & DEF_MASK) == ($past(activeQ) & DEF_MASK)));
  assert_deferred_latch_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchDeferred |=> ((activeQ & DEF_MASK) == ($past(shadowQ) & DEF_MASK)));
  assert_imm_apply_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadImmediate |=> ((activeQ & IMM_MASK) == ($past(wrData) & IMM_MASK)));
  assert_readback_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadShadow |=> (shadowQ == $past(wrData)));
  assert_addr_en_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({diagRdAddrEn, diagWrAddrEn}) && (diagMode || !(diagRdAddrEn || diagWrAddrEn)));
endmodule

// File: rtl/fsync_ctl_reg.sv
`timescale 1ns/1ps
module fsync_ctl_reg
  import fsync_ctl_pkg::*;
#(
  parameter int                 W        = CFG_W,
  parameter logic [CFG_W-1:0]   IMM_MASK = 32'hFE00_0000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busWrEn,
  input  logic [W-1:0] busWrData,
  output logic [W-1:0] busRdData,
  input  logic         frameStart,
  output logic [W-1:0] activeCfg,
  output logic         dbgEnable,
  output logic         dbgSelMem,
  output logic         diagMode,
  output logic         diagRdAddrEn,
  output logic         diagWrAddrEn,
  output logic         crcModeSel,
  output logic         sigFreeRun,
  output logic         sigRdEn,
  output logic         ptrClear
);
  cfgStrobe_t strobe;

  fsync_ctl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .frameStart(frameStart),
    .diagActive(diagMode), .strobe(strobe), .ptrClear(ptrClear)
  );

  fsync_ctl_data #(.W(W), .IMM_MASK(IMM_MASK)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .shadowWord(busRdData), .activeWord(activeCfg),
    .dbgEnable(dbgEnable), .dbgSelMem(dbgSelMem), .diagMode(diagMode),
    .diagRdAddrEn(diagRdAddrEn), .diagWrAddrEn(diagWrAddrEn),
    .crcModeSel(crcModeSel), .sigFreeRun(sigFreeRun), .sigRdEn(sigRdEn)
  );
endmodule

// File: tb/tb_fsync_ctl_reg.sv
`timescale 1ns/1ps
module tb_fsync_ctl_reg;
  localparam logic [31:0] IMM = 32'hFE00_0000;

  logic clk = 1'b0, rstN = 1'b0, busWrEn = 1'b0, frameStart = 1'b0;
  logic [31:0] busWrData = '0, busRdData, activeCfg;
  logic dbgEnable, dbgSelMem, diagMode, diagRdAddrEn, diagWrAddrEn;
  logic crcModeSel, sigFreeRun, sigRdEn, ptrClear;

  always #2.5 clk = ~clk;

  fsync_ctl_reg dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .frameStart(frameStart), .activeCfg(activeCfg),
    .dbgEnable(dbgEnable), .dbgSelMem(dbgSelMem), .diagMode(diagMode),
    .diagRdAddrEn(diagRdAddrEn), .diagWrAddrEn(diagWrAddrEn),
    .crcModeSel(crcModeSel), .sigFreeRun(sigFreeRun), .sigRdEn(sigRdEn),
    .ptrClear(ptrClear)
  );

  typedef struct { string tag; int kind; logic [31:0] exp; } item_t;
  item_t sb[$];
  int total = 0, fails = 0;
  bit done = 0;
  logic [31:0] mShadow = '0, mActive = '0;

  function automatic logic [31:0] fieldPack(input logic [31:0] a);
    // R4 positions, R5 enables
    return {24'd0, a[31], a[30], a[28], a[27], a[26], a[25],
            a[28] & a[29], a[28] & ~a[29]};
  endfunction

  function automatic logic [31:0] observe(input int kind);
    case (kind)
      0: return activeCfg;
      1: return busRdData;
      2: return {31'd0, ptrClear};
      default: return {24'd0, dbgEnable, dbgSelMem, diagMode, crcModeSel,
                       sigFreeRun, sigRdEn, diagRdAddrEn, diagWrAddrEn};
    endcase
  endfunction

  task automatic pushAll(input string tag, input logic expPtr);
    sb.push_back('{tag, 0, mActive});
    sb.push_back('{tag, 1, mShadow});
    sb.push_back('{tag, 2, {31'd0, expPtr}});
    sb.push_back('{tag, 3, fieldPack(mActive)});
  endtask

  task automatic step(input logic we, input logic [31:0] wd, input logic fs, input string tag);
    logic [31:0] old;
    busWrEn = we; busWrData = wd; frameStart = fs;
    @(posedge clk);
    old = mActive;
    if (fs) mActive = (mActive & IMM) | (mShadow & ~IMM);
    if (we) begin
      mActive = (mActive & ~IMM) | (wd & IMM);
      mShadow = wd;
    end
    #1;
    busWrEn = 1'b0; frameStart = 1'b0;
    pushAll(tag, mActive[28] & ~old[28]);
  endtask

  always @(negedge clk) begin
    item_t it;
    logic [31:0] got;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      got = observe(it.kind);
      total++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s kind%0d: actual %h expected %h", it.tag, it.kind, got, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    pushAll("R1", 1'b0);                      // R1 reset state
    step(1, 32'h0000_1234, 0, "R7");          // R7 readback of pending; R2 active unchanged
    step(0, 32'h0, 0, "R2");
    step(0, 32'h0, 0, "R2");
    step(0, 32'h0, 1, "R2");                  // R2 frame start applies 1234
    step(1, 32'h9000_0000, 0, "R6");          // R6 rise pulse, R3 immediate, R5 write addr
    step(0, 32'h0, 0, "R6");                  // R6 one cycle only
    step(1, 32'hB000_0000, 0, "R5");          // R5 read addr, no new pulse
    step(1, 32'h0C00_0000, 0, "R4");          // R4 fields, R6 no pulse on fall
    step(1, 32'h4200_5555, 1, "R8");          // R8 write with frame start
    step(0, 32'h0, 0, "R8");
    step(0, 32'h0, 1, "R8");                  // R8 applied at next frame start
    step(1, 32'hFE00_0000, 0, "R3");          // R3 all immediate bits, R6 rise again
    step(1, 32'h6400_0000, 1, "R3");          // R3 immediate with frame start
    repeat (2) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule